// File: doc/BRIEF.md
# Transmit Phase-Realigning Nibble FIFO and Serializer

The block moves 4-bit transmit words from an upstream write clock into a locally generated byte timing and shifts them out serially. Words are taken on every rising edge of the write clock and stored in a small circular buffer. The read side runs from a bit-rate clock; an internal divide-by-four forms the byte slot, and one word is drawn from the buffer per slot. The write pointer reaches the read side as a Gray code through a two-flop synchronizer.

Once per byte slot the read side measures the distance between the synchronized write pointer and its own read pointer. When the distance comes close to either end of the buffer, a phase-error flag is raised for that slot. A realignment request on the phase-init input moves the read pointer back to the middle of the buffer. That request counts only after it has stayed high for a minimum number of read cycles. The serializer then sends all-zero words for half a buffer's worth of slots and picks up the stream again in order. The first centering after reset happens without any request. Wiring the phase-error output back to the phase-init input turns the block into a self-healing elastic stage.

Top module: `tx_realign_fifo_ser`

## Requirements
- R1: While the read-side reset is asserted, `ser_out` and `phase_err` are 0.
- R2: Each word takes 4 consecutive read cycles on `ser_out`, bit 3 first and bit 0 last. `nib_start` is high in the cycle that carries bit 3. Words leave in the order in which the write clock captured them on its rising edges.
- R3: At each byte-slot boundary the block computes the separation (synchronized write pointer minus read pointer, modulo DEPTH). If it is at most 1 or at least DEPTH-1, `phase_err` is 1 for the following slot; otherwise it is 0. `phase_err` changes only at slot boundaries.
- R4: An accepted realignment takes effect at the next slot boundary. The read pointer is set to DEPTH/2-1 entries behind the synchronized write pointer. Exactly DEPTH/2 all-zero words follow (4 with the default), then the stream resumes in order, and at most 10 words are lost.
- R5: The first slot boundary after reset performs a centering by itself, and `phase_err` stays 0 until then. While the two clocks keep a fixed 4:1 frequency ratio, `phase_err` does not rise after that centering.
- R6: `phase_init` is synchronized to the read clock. It is accepted once, when its synchronized level has been high for INIT_MIN consecutive read cycles (default 4, one byte slot). A shorter pulse causes no realignment, and a level held high causes only one.
- R7: With `phase_err` tied to `phase_init`, frequency drift between the clocks produces repeated, short error pulses, each cleared by an automatic realignment, while data keeps flowing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; words are captured on its rising edge |
| wr_rst_n | input | 1 | Active-low asynchronous reset of the write side |
| wr_data | input | 4 | Transmit word, bit 3 sent first |
| rd_clk | input | 1 | Bit-rate clock of the read side and serializer |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read side |
| phase_init | input | 1 | Realignment request, acted on at its qualified rising edge |
| phase_err | output | 1 | High for a byte slot when the pointers are near collision |
| ser_out | output | 1 | Serial data, one bit per read cycle |
| nib_start | output | 1 | Marks the read cycle that carries bit 3 of a word |

## Verification
The bench drives a non-zero ring pattern of words. Any break, reversal or repeat then shows up as a sequence break, and inserted zero words stand out. A serializer that sent bit 0 first, or a pointer that skipped entries, would break the sequence even with locked clocks. The bench speeds up and slows down the read clock to push the separation toward each end of the buffer. A wrong threshold or a missing wrap case would then never raise `phase_err`, or would raise it with locked clocks. It sends a one-cycle init glitch and a long-held init level. A design without a width filter would realign on the glitch, and one that acts on level rather than edge would realign many times. In self-healing mode, a loop that never clears would show as an error pulse without bound and a stalled stream.

// File: rtl/tx_rfs_pkg.sv
package tx_rfs_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/tx_rfs_sync.sv
module tx_rfs_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/tx_rfs_wr_side.sv
module tx_rfs_wr_side
  import tx_rfs_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst_n,
  input  nib_t                     wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output nib_t                     rd_data,
  output logic [$clog2(DEPTH)-1:0] wptr_gray
);
  localparam int unsigned PW = $clog2(DEPTH);

  nib_t            store_q [DEPTH];
  logic [PW-1:0]   wptr_q, wptr_d;
  logic [PW-1:0]   gray_q, gray_d;

  always_comb begin
    wptr_d = wptr_q + PW'(1);
    gray_d = wptr_d ^ (wptr_d >> 1);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wptr_q <= '0;
      gray_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      gray_q <= gray_d;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst_n) begin
      store_q[wptr_q] <= wr_data;
    end
  end

  assign rd_data   = store_q[rd_addr];
  assign wptr_gray = gray_q;
endmodule

// File: rtl/tx_rfs_rd_ctrl.sv
module tx_rfs_rd_ctrl #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned INIT_MIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_tick,
  input  logic [$clog2(DEPTH)-1:0] wgray_s,
  input  logic                     init_lvl,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     load_zero,
  output logic                     center_go,
  output logic                     arm,
  output logic                     centered,
  output logic                     phase_err
);
  localparam int unsigned PW   = $clog2(DEPTH);
  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned CW   = $clog2(INIT_MIN + 1);
  localparam int unsigned BW   = $clog2(HALF + 1);

  logic [PW-1:0] wbin;
  logic [PW-1:0] sep;
  logic          tight;
  logic          acc;

  logic [PW-1:0] rptr_q, rptr_d;
  logic [BW-1:0] blank_q, blank_d;
  logic [CW-1:0] hi_q, hi_d;
  logic          pend_q, pend_d;
  logic          cent_q, cent_d;
  logic          err_q, err_d;

  always_comb begin
    acc  = 1'b0;
    wbin = '0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc     = acc ^ wgray_s[i];
      wbin[i] = acc;
    end
  end

  always_comb begin
    sep   = wbin - rptr_q;
    tight = (sep <= PW'(1)) || (sep >= PW'(DEPTH - 1));

    if (!init_lvl)                   hi_d = '0;
    else if (hi_q != CW'(INIT_MIN))  hi_d = hi_q + CW'(1);
    else                             hi_d = hi_q;
    arm = init_lvl && (hi_q == CW'(INIT_MIN - 1));

    center_go = byte_tick && (pend_q || !cent_q);
    pend_d    = arm || (pend_q && !center_go);
    cent_d    = cent_q || center_go;

    rptr_d  = rptr_q;
    blank_d = blank_q;
    err_d   = err_q;
    if (center_go) begin
      rptr_d  = wbin - PW'(HALF - 1);
      blank_d = BW'(HALF - 1);
      err_d   = 1'b0;
    end else if (byte_tick) begin
      rptr_d = rptr_q + PW'(1);
      if (blank_q != '0) blank_d = blank_q - BW'(1);
      err_d = cent_q && tight;
    end

    load_zero = center_go || (blank_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      blank_q <= '0;
      hi_q    <= '0;
      pend_q  <= 1'b0;
      cent_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      blank_q <= blank_d;
      hi_q    <= hi_d;
      pend_q  <= pend_d;
      cent_q  <= cent_d;
      err_q   <= err_d;
    end
  end

  assign rd_addr   = rptr_q;
  assign centered  = cent_q;
  assign phase_err = err_q;
endmodule

// File: rtl/tx_rfs_ser.sv
module tx_rfs_ser
  import tx_rfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  nib_t load_word,
  output logic byte_tick,
  output logic ser_out,
  output logic nib_start
);
  localparam int unsigned CNW = $clog2(NIB_W);

  logic [CNW-1:0] cnt_q, cnt_d;
  nib_t           sh_q, sh_d;

  always_comb begin
    byte_tick = (cnt_q == CNW'(NIB_W - 1));
    if (byte_tick) begin
      cnt_d = '0;
      sh_d  = load_word;
    end else begin
      cnt_d = cnt_q + CNW'(1);
      sh_d  = {sh_q[NIB_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign ser_out   = sh_q[NIB_W-1];
  assign nib_start = (cnt_q == '0);
endmodule

// File: rtl/tx_realign_fifo_ser.sv
module tx_realign_fifo_ser
  import tx_rfs_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned INIT_MIN = 4
) (
  input  logic       wr_clk,
  input  logic       wr_rst_n,
  input  logic [3:0] wr_data,
  input  logic       rd_clk,
  input  logic       rd_rst_n,
  input  logic       phase_init,
  output logic       phase_err,
  output logic       ser_out,
  output logic       nib_start
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0] wgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rd_addr;
  nib_t          rd_data;
  nib_t          load_word;
  logic          load_zero;
  logic          tick_w;
  logic          init_lvl;
  logic          center_go;
  logic          arm;
  logic          centered;

  tx_rfs_wr_side #(.DEPTH(DEPTH)) wr_i (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wptr_gray (wgray)
  );

  tx_rfs_sync #(.W(PW)) ptr_sync_i (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wgray),
    .q     (wgray_s)
  );

  tx_rfs_sync #(.W(1)) init_sync_i (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (phase_init),
    .q     (init_lvl)
  );

  tx_rfs_rd_ctrl #(.DEPTH(DEPTH), .INIT_MIN(INIT_MIN)) rd_i (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .byte_tick (tick_w),
    .wgray_s   (wgray_s),
    .init_lvl  (init_lvl),
    .rd_addr   (rd_addr),
    .load_zero (load_zero),
    .center_go (center_go),
    .arm       (arm),
    .centered  (centered),
    .phase_err (phase_err)
  );

  assign load_word = load_zero ? '0 : rd_data;

  tx_rfs_ser ser_i (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .load_word (load_word),
    .byte_tick (tick_w),
    .ser_out   (ser_out),
    .nib_start (nib_start)
  );
endmodule

// File: rtl/tx_realign_fifo_ser_chk.sv
module tx_realign_fifo_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_tick,
  input logic phase_err,
  input logic ser_out,
  input logic nib_start,
  input logic center_go,
  input logic arm,
  input logic init_lvl,
  input logic centered
);
  // R3
  err_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_tick |=> $stable(phase_err));

  // R4
  blank_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    center_go |=> (nib_start && !ser_out));

  // R5
  precenter_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !centered |-> !phase_err);

  // R6
  init_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (init_lvl && $past(init_lvl)));

  // R2
  word_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_start |=> !nib_start);

  // R2
  tick_to_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_tick |=> nib_start);
endmodule

bind tx_realign_fifo_ser tx_realign_fifo_ser_chk chk_i (
  .clk       (rd_clk),
  .rst_n     (rd_rst_n),
  .byte_tick (tick_w),
  .phase_err (phase_err),
  .ser_out   (ser_out),
  .nib_start (nib_start),
  .center_go (center_go),
  .arm       (arm),
  .init_lvl  (init_lvl),
  .centered  (centered)
);

// File: tb/tx_realign_fifo_ser_tb.sv
`timescale 1ns/1ps
module tx_realign_fifo_ser_tb_top;
  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       wr_rst_n = 1'b0;
  logic       rd_rst_n = 1'b0;
  logic [3:0] wr_data = 4'd1;
  logic       init_drv = 1'b0;
  logic       auto_mode = 1'b0;
  logic       phase_init;
  logic       phase_err;
  logic       ser_out;
  logic       nib_start;
  real        rd_half = 2.0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // monitor state
  int       words = 0, nz = 0, zrun = 0, zero_runs = 0, breaks = 0;
  int       last_gap = 0, last_zrun = 0;
  int       err_rises = 0, err_run = 0, err_max = 0;
  logic     err_d = 1'b0;
  logic [3:0] prev = 4'd0;
  bit       have_prev = 0;
  logic [3:0] cur = 4'd0;
  int       idx = 0;

  assign phase_init = auto_mode ? phase_err : init_drv;

  tx_realign_fifo_ser dut_i (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .wr_data    (wr_data),
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .phase_init (phase_init),
    .phase_err  (phase_err),
    .ser_out    (ser_out),
    .nib_start  (nib_start)
  );

  initial begin
    #1;
    forever #8 wr_clk = ~wr_clk;
  end

  initial begin
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  // ring pattern 1..15, zero never sent
  initial begin
    forever begin
      @(negedge wr_clk);
      if (wr_rst_n) wr_data <= (wr_data == 4'd15) ? 4'd1 : wr_data + 4'd1;
    end
  end

  task automatic take_word(input logic [3:0] w);
    int d;
    words++;
    if (w == 4'd0) begin
      zrun++;
    end else begin
      if (have_prev) begin
        d = (int'(w) - int'(prev) + 15) % 15;
        if (d != 1) begin
          breaks++;
          last_gap  = (d + 14) % 15;
          last_zrun = zrun;
        end
      end
      if (zrun > 0) zero_runs++;
      zrun = 0;
      prev = w;
      have_prev = 1;
      nz++;
    end
  endtask

  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (nib_start) begin
        cur = {3'b000, ser_out};
        idx = 1;
      end else if (idx > 0 && idx < 4) begin
        cur = {cur[2:0], ser_out};
        idx++;
        if (idx == 4) take_word(cur);
      end
      if (phase_err && !err_d) err_rises++;
      if (phase_err) begin
        err_run++;
        if (err_run > err_max) err_max = err_run;
      end else begin
        err_run = 0;
      end
      err_d = phase_err;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    breaks = 0; zero_runs = 0; nz = 0; err_rises = 0; err_max = 0;
    last_gap = 0; last_zrun = 0;
  endtask

  task automatic wait_words(input int n);
    int target;
    target = words + n;
    while (words < target) @(negedge rd_clk);
  endtask

  task automatic init_pulse(input int cyc);
    @(negedge rd_clk);
    init_drv = 1'b1;
    repeat (cyc) @(negedge rd_clk);
    init_drv = 1'b0;
  endtask

  task automatic t_reset();
    repeat (6) @(negedge rd_clk);
    check(ser_out == 1'b0, "R1 ser_out in reset", int'(ser_out), 0);
    check(phase_err == 1'b0, "R1 phase_err in reset", int'(phase_err), 0);
    @(negedge rd_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
  endtask

  task automatic t_locked();
    wait_words(20);
    clear_stats();
    wait_words(100);
    check(breaks == 0, "R2 in-order msb-first stream", breaks, 0);
    check(zero_runs == 0 && zrun == 0, "R2 no zero words", zero_runs, 0);
    check(nz >= 100, "R2 word count", nz, 100);
    check(err_rises == 0, "R5 no phase_err when locked", err_rises, 0);
  endtask

  task automatic t_realign();
    clear_stats();
    init_pulse(8);
    wait_words(30);
    check(breaks == 1, "R4 one realignment", breaks, 1);
    check(last_zrun == 4, "R4 blank words", last_zrun, 4);
    check(last_gap <= 10, "R4 loss bound", last_gap, 10);
    check(err_rises == 0, "R4 no error after realign", err_rises, 0);
  endtask

  task automatic t_init_width();
    clear_stats();
    init_pulse(1);
    wait_words(30);
    check(breaks == 0 && zero_runs == 0, "R6 short pulse ignored", breaks + zero_runs, 0);
    clear_stats();
    init_pulse(200);
    wait_words(30);
    check(zero_runs == 1, "R6 held level realigns once", zero_runs, 1);
  endtask

  task automatic t_drift(input real half, input string tag);
    int lim;
    clear_stats();
    rd_half = half;
    lim = words + 400;
    while (err_rises == 0 && words < lim) @(negedge rd_clk);
    check(err_rises >= 1, tag, err_rises, 1);
    rd_half = 2.0;
    init_pulse(8);
    wait_words(30);
    clear_stats();
    wait_words(60);
    check(err_rises == 0 && phase_err == 1'b0, "R3 error clear after recenter", err_rises, 0);
  endtask

  task automatic t_auto();
    auto_mode = 1'b1;
    rd_half = 1.9;
    wait_words(10);
    clear_stats();
    wait_words(600);
    check(err_rises >= 2, "R7 repeated self-heal", err_rises, 2);
    check(err_max <= 24, "R7 error pulse bounded", err_max, 24);
    check(nz >= 400, "R7 data keeps flowing", nz, 400);
    rd_half = 2.0;
    wait_words(40);
    clear_stats();
    wait_words(80);
    check(err_rises == 0, "R7 quiet once locked", err_rises, 0);
    auto_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_locked();
    t_realign();
    t_init_width();
    t_drift(1.9, "R3 near-empty side flagged");
    t_drift(2.1, "R3 near-full side flagged");
    t_auto();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rd_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule